// File: doc/BRIEF.md
# Sleep Interval Timer with Watchdog and Supply-Detector Gating

This block turns a slow, always-running reference clock into a periodic wake-up tick for a low-power system. The reference is first divided down to a 512 Hz base rate, and a 2-bit interval select then picks how many base periods form one sleep period: 1, 8, 64 or 512. The result is a tick at 512 Hz, 64 Hz, 8 Hz or 1 Hz. Each tick is a single-cycle pulse.

A watchdog counts sleep ticks and fires a one-cycle reset pulse on the third tick, unless software restarts its count with a clear strobe. Its timeout is therefore tied to three sleep periods at any interval.

The block also drives the enable of an external supply-monitor detector. Outside sleep the enable is high. During sleep, it follows a duty-cycle pattern supplied on an input, or it is held high all the time when an override bit is set. This duty cycling does not depend on the sleep interval.

Top module: `sleep_wd_timer`

## Requirements
- R1: While reset is held, sleepTick and wdReset are 0 and detEn is 1. The interval select is taken as 00 and the override as 0 at reset.
- R2: sleepTick is a one-cycle pulse. It repeats every BASE_DIV × 8^intervalSel clock cycles. The select encoding is 00 → 1, 01 → 8, 10 → 64 and 11 → 512 base periods.
- R3: With no clear and no select change, wdReset is a one-cycle pulse. It coincides with every third sleepTick.
- R4: A wdClear pulse restarts the watchdog count. The next wdReset comes with the third sleepTick after the clear. No wdReset appears in the cycle after a clear, and clearing at least once every two ticks keeps wdReset low.
- R5: Changing intervalSel restarts both the prescaler and the watchdog count. No tick appears in the cycle after the change. The first new tick appears BASE_DIV × 8^intervalSel + 1 clock edges after the select was driven.
- R6: With sleepFlag low, detEn is 1 one clock edge later, whatever the other detector inputs are.
- R7: With sleepFlag high and overrideOn low, detEn equals the dutyStrobe value sampled at the previous clock edge.
- R8: With sleepFlag and overrideOn both high, dutyStrobe is ignored and detEn stays 1.
- R9: detEn does not depend on intervalSel. Changing the select during sleep leaves the duty-cycled enable unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow reference clock, BASE_DIV cycles per 512 Hz base period |
| rstN | input | 1 | Active-low synchronous reset |
| sleepFlag | input | 1 | High while the system is asleep |
| intervalSel | input | SEL_W | Sleep interval select, 8^value base periods per tick |
| overrideOn | input | 1 | Holds the detector enable high during sleep |
| dutyStrobe | input | 1 | Duty-cycle pattern for the detector enable during sleep |
| wdClear | input | 1 | One-cycle strobe that restarts the watchdog count |
| sleepTick | output | 1 | One-cycle sleep wake-up pulse |
| wdReset | output | 1 | One-cycle watchdog expiry pulse |
| detEn | output | 1 | Supply-monitor detector enable |

## Verification
The assertions assume wdClear and intervalSel change only at clock edges, after reset has been released. They also assume BASE_DIV is at least 2, so that two sleep ticks can never fall in back-to-back cycles. The bench drives every input at the falling edge and uses BASE_DIV of 2. It changes the select only to a value that differs from the current one, so that every change it makes is a real restart. It spaces clear strobes no closer than the assertions allow.

// File: rtl/sleep_wd_pkg.sv
package sleep_wd_pkg;

  // Strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic restartPrescale;  // clear base divider and interval counter
    logic restartWatchdog;  // clear watchdog tick count
  } tmrStrobe_t;

endpackage

// File: rtl/sleep_wd_datapath.sv
module sleep_wd_datapath
  import sleep_wd_pkg::*;
#(
  parameter int BASE_DIV  = 64,
  parameter int SEL_W     = 2,
  parameter int STEP_LOG2 = 3,
  parameter int WD_TICKS  = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] intervalSel,
  input  tmrStrobe_t       strobe,
  output logic             sleepTick,
  output logic             wdExpire
);

  localparam int NUM_SEL  = 1 << SEL_W;
  localparam int BASE_W   = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1;
  localparam int INT_W    = (STEP_LOG2 * (NUM_SEL - 1) > 0) ? STEP_LOG2 * (NUM_SEL - 1) : 1;
  localparam int WD_W     = (WD_TICKS > 1) ? $clog2(WD_TICKS) : 1;

  logic [BASE_W-1:0] baseCnt;
  logic [INT_W-1:0]  intervalCnt;
  logic [WD_W-1:0]   wdCnt;
  logic [INT_W:0]    lastTab [NUM_SEL];
  logic [INT_W:0]    lastIdx;
  logic              baseLast;
  logic              intervalLast;
  logic              tickRaw;

  // Last interval index for each select value: 8^sel - 1
  for (genvar g = 0; g < NUM_SEL; g++) begin : g_lim
    assign lastTab[g] = (INT_W+1)'((1 << (STEP_LOG2 * g)) - 1);
  end

  assign lastIdx      = lastTab[intervalSel];
  assign baseLast     = (baseCnt == BASE_W'(BASE_DIV - 1));
  assign intervalLast = ({1'b0, intervalCnt} == lastIdx);
  assign tickRaw      = baseLast && intervalLast;

  // Base divider: reference clock down to the 512 Hz base
  always_ff @(posedge clk) begin
    if (!rstN || strobe.restartPrescale || baseLast) baseCnt <= '0;
    else                                             baseCnt <= baseCnt + BASE_W'(1);
  end

  // Interval counter: base periods per sleep tick
  always_ff @(posedge clk) begin
    if (!rstN || strobe.restartPrescale) intervalCnt <= '0;
    else if (baseLast) begin
      if (intervalLast) intervalCnt <= '0;
      else              intervalCnt <= intervalCnt + INT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) sleepTick <= 1'b0;
    else       sleepTick <= tickRaw && !strobe.restartPrescale;
  end

  // Watchdog tick count, wraps after WD_TICKS ticks
  always_ff @(posedge clk) begin
    if (!rstN || strobe.restartWatchdog) wdCnt <= '0;
    else if (tickRaw) begin
      if (wdCnt == WD_W'(WD_TICKS - 1)) wdCnt <= '0;
      else                              wdCnt <= wdCnt + WD_W'(1);
    end
  end

  assign wdExpire = tickRaw && !strobe.restartWatchdog && (wdCnt == WD_W'(WD_TICKS - 1));

  // R2
  tick_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    sleepTick |=> !sleepTick);

  // R5
  restart_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.restartPrescale |=> !sleepTick);

endmodule

// File: rtl/sleep_wd_control.sv
module sleep_wd_control
  import sleep_wd_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] intervalSel,
  input  logic             sleepFlag,
  input  logic             overrideOn,
  input  logic             dutyStrobe,
  input  logic             wdClear,
  input  logic             wdExpire,
  input  logic             sleepTick,
  output tmrStrobe_t       strobe,
  output logic             wdReset,
  output logic             detEn
);

  logic [SEL_W-1:0] selPrev;
  logic             selChange;

  always_ff @(posedge clk) begin
    if (!rstN) selPrev <= '0;
    else       selPrev <= intervalSel;
  end

  assign selChange              = (intervalSel != selPrev);
  assign strobe.restartPrescale = selChange;
  assign strobe.restartWatchdog = selChange || wdClear;

  always_ff @(posedge clk) begin
    if (!rstN) wdReset <= 1'b0;
    else       wdReset <= wdExpire;
  end

  // Detector enable: high awake, duty pattern or forced high asleep
  always_ff @(posedge clk) begin
    if (!rstN) detEn <= 1'b1;
    else       detEn <= !sleepFlag || overrideOn || dutyStrobe;
  end

  // R3
  wd_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    wdReset |-> sleepTick);

  // R3
  wd_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    wdReset |=> !wdReset);

  // R4
  clear_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    wdClear |=> !wdReset);

  // R6
  awake_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sleepFlag |=> detEn);

  // R8
  override_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sleepFlag && overrideOn) |=> detEn);

endmodule

// File: rtl/sleep_wd_timer.sv
module sleep_wd_timer
  import sleep_wd_pkg::*;
#(
  parameter int BASE_DIV  = 64,
  parameter int SEL_W     = 2,
  parameter int STEP_LOG2 = 3,
  parameter int WD_TICKS  = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sleepFlag,
  input  logic [SEL_W-1:0] intervalSel,
  input  logic             overrideOn,
  input  logic             dutyStrobe,
  input  logic             wdClear,
  output logic             sleepTick,
  output logic             wdReset,
  output logic             detEn
);

  tmrStrobe_t strobe;
  logic       wdExpire;

  sleep_wd_control #(.SEL_W(SEL_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .intervalSel (intervalSel),
    .sleepFlag   (sleepFlag),
    .overrideOn  (overrideOn),
    .dutyStrobe  (dutyStrobe),
    .wdClear     (wdClear),
    .wdExpire    (wdExpire),
    .sleepTick   (sleepTick),
    .strobe      (strobe),
    .wdReset     (wdReset),
    .detEn       (detEn)
  );

  sleep_wd_datapath #(
    .BASE_DIV  (BASE_DIV),
    .SEL_W     (SEL_W),
    .STEP_LOG2 (STEP_LOG2),
    .WD_TICKS  (WD_TICKS)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .intervalSel (intervalSel),
    .strobe      (strobe),
    .sleepTick   (sleepTick),
    .wdExpire    (wdExpire)
  );

endmodule

// File: tb/sim_sleep_wd_timer.sv
`timescale 1ns/1ps
module sim_sleep_wd_timer;

  localparam int BDIV = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sleepFlag = 1'b0;
  logic [1:0] intervalSel = 2'b00;
  logic       overrideOn = 1'b0;
  logic       dutyStrobe = 1'b0;
  logic       wdClear = 1'b0;
  logic       sleepTick;
  logic       wdReset;
  logic       detEn;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sleep_wd_timer #(.BASE_DIV(BDIV)) u0 (
    .clk(clk), .rstN(rstN), .sleepFlag(sleepFlag), .intervalSel(intervalSel),
    .overrideOn(overrideOn), .dutyStrobe(dutyStrobe), .wdClear(wdClear),
    .sleepTick(sleepTick), .wdReset(wdReset), .detEn(detEn)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(sleepTick == 1'b0, "R1 tick", sleepTick, 0);
    check(wdReset == 1'b0, "R1 wdReset", wdReset, 0);
    check(detEn == 1'b1, "R1 detEn", detEn, 1);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // Select change then tick period for one select value
  task automatic t_period(input int s);
    int lim = BDIV * (1 << (3 * s));
    int cnt = 0;
    @(negedge clk);
    intervalSel = s[1:0];
    @(posedge clk); cnt++;
    @(negedge clk);
    check(sleepTick == 1'b0, "R5 quiet after change", sleepTick, 0);
    while (!sleepTick && cnt < 5000) begin
      @(posedge clk); cnt++;
      @(negedge clk);
    end
    check(cnt == lim + 1, "R5 first tick", cnt, lim + 1);
    cnt = 1;
    @(posedge clk);
    @(negedge clk);
    check(sleepTick == 1'b0, "R2 pulse width", sleepTick, 0);
    while (!sleepTick && cnt < 5000) begin
      @(posedge clk); cnt++;
      @(negedge clk);
    end
    check(cnt == lim, "R2 period", cnt, lim);
  endtask

  // Clear, then watch six ticks: reset on the 3rd and 6th
  task automatic t_watchdog();
    int guard;
    @(negedge clk);
    wdClear = 1'b1;
    @(negedge clk);
    wdClear = 1'b0;
    check(wdReset == 1'b0, "R4 no reset after clear", wdReset, 0);
    for (int n = 1; n <= 6; n++) begin
      guard = 0;
      do begin
        @(posedge clk);
        @(negedge clk);
        guard++;
      end while (!sleepTick && guard < 5000);
      check(wdReset == (n % 3 == 0), "R3 reset on third tick", wdReset, (n % 3 == 0));
    end
  endtask

  // Clear every two ticks: watchdog never fires
  task automatic t_clear_hold();
    int seen = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      wdClear = 1'b1;
      if (wdReset) seen++;
      @(negedge clk);
      wdClear = 1'b0;
      if (wdReset) seen++;
      repeat (2) begin
        @(negedge clk);
        if (wdReset) seen++;
      end
    end
    check(seen == 0, "R4 periodic clear holds off", seen, 0);
  endtask

  task automatic t_detector();
    logic [7:0] pat = 8'b1011_0010;
    int bad = 0;
    @(negedge clk);
    sleepFlag = 1'b0; overrideOn = 1'b0; dutyStrobe = 1'b0;
    @(negedge clk);
    check(detEn == 1'b1, "R6 awake enable", detEn, 1);
    sleepFlag = 1'b1;
    for (int i = 0; i < 8; i++) begin
      dutyStrobe = pat[i];
      @(negedge clk);
      check(detEn == pat[i], "R7 duty follow", detEn, pat[i]);
    end
    overrideOn = 1'b1;
    for (int i = 0; i < 8; i++) begin
      dutyStrobe = pat[i];
      @(negedge clk);
      check(detEn == 1'b1, "R8 override holds", detEn, 1);
    end
    overrideOn = 1'b0;
    dutyStrobe = 1'b0;
    @(negedge clk);
    check(detEn == 1'b0, "R7 duty low", detEn, 0);
    intervalSel = ~intervalSel;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (detEn !== 1'b0) bad++;
    end
    check(bad == 0, "R9 select has no effect", bad, 0);
    dutyStrobe = 1'b1;
    @(negedge clk);
    check(detEn == 1'b1, "R9 duty still followed", detEn, 1);
    sleepFlag = 1'b0;
    dutyStrobe = 1'b0;
    @(negedge clk);
    check(detEn == 1'b1, "R6 wake enable", detEn, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog timeout actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_period(1);
    t_period(2);
    t_period(3);
    t_period(0);
    t_watchdog();
    t_clear_hold();
    t_period(1);
    t_watchdog();
    t_detector();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule